// File: doc/BRIEF.md
# Recursive Triple-Redundant Encoded NAND

This block is a purely combinational NAND that works on encoded data. Each logical bit is carried in a three-copy repetition code. That code is nested inside itself `K` times, so every operand and the result are `3^K` bits wide. The block is built from plain two-input NAND cells and three-input majority cells. The voting is distributed: each majority stage produces three voted copies, so the result is never reduced to a single bit anywhere inside the block. A following block of the same kind can take the result directly as an encoded operand.

Every NAND cell and every majority cell has its own fault-injection bit. When that bit is set, the cell's output is inverted. A test environment can use these bits to place upsets at known sites and confirm that the encoded result still carries the correct logical value.

Top module: `rtmr_nand_enc`

## Requirements
- R1: The parameter `K` selects the nesting depth. It may be 0, 1 or 2, and any other value stops elaboration. Operands and the result are `W = 3^K` bits wide. At every level, a codeword of `3^L` bits consists of three sub-codewords of `3^(L-1)` bits each. Sub-codeword `j` occupies bits `j*3^(L-1)` upward.
- R2: Stage 0 has one NAND cell per bit position. Cell `i` computes the NAND of `op_a[i]` and `op_b[i]`. When `nand_flip[i]` is 1, that cell's output is inverted.
- R3: Voter stage `L` (1..K) works in blocks of `3^L` bits, and `S = 3^(L-1)`. Output bit `off + r*S + p` is the majority of input bits `off+p`, `off+S+p` and `off+2S+p`, for every copy `r` in 0..2. The output of that voter is inverted when `vote_flip[(L-1)*W + off + r*S + p]` is 1. Stage `K` drives `res`.
- R4: With no fault bits set and both operands uniform (all zeros or all ones), every bit of `res` equals the NAND of the two operand values.
- R5: Uniform operands may be combined with any single fault bit. The recursive decode of `res` still equals the NAND of the decoded operands. The recursive decode takes the majority of each consecutive triple, then repeats on the shorter vector until one bit remains.
- R6: A single fault in stage 0, or in any voter stage below `K`, leaves `res` bit-exact. A single fault on final-stage voter `q` inverts exactly `res[q]`.
- R7: Two fault bits may be set in different top-level groups. The group of a site is its bit position divided by `3^(K-1)`. With uniform operands, `res` still decodes to the correct NAND.
- R8: Suppose two whole sub-blocks below the final stage produce inverted codewords, for example from two NAND faults in each of two stage-1 blocks. Then every final voter sees a two-to-one wrong majority, and all of `res` is inverted.
- R9: An operand with one top-level group inverted is corrected. Given that operand and a uniform second operand, the fault-free result is the uniform codeword of the NAND of the decoded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First encoded operand |
| op_b | input | W | Second encoded operand |
| nand_flip | input | W | One inversion bit per stage-0 NAND cell |
| vote_flip | input | K*W (1 when K=0) | One inversion bit per majority cell, indexed stage-major |
| res | output | W | Encoded NAND result |

## Verification
The embedded assertions check, on every input change, the properties that can be stated locally. A fault-free stage passes uniform input through unchanged. A single inverted voter on uniform input changes exactly one output bit. A clean run on codeword operands yields a codeword. With at most one fault anywhere, the result decodes correctly. Only the bench's scenarios can show the behaviour that depends on where faults sit relative to one another. These cover bit-exact masking of faults below the final stage, tolerance of pairs spread across separate groups, total inversion when two sub-blocks fail together, and correction of a deviating operand group.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;

    function automatic int pow3(input int n);
        int r;
        r = 1;
        for (int i = 0; i < n; i++) r = r * 3;
        return r;
    endfunction

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    // Recursive decode of a codeword of up to two nesting levels:
    // reduce consecutive triples, depth times.
    function automatic logic decode9(input logic [8:0] v, input int depth);
        logic [8:0] cur;
        int n;
        cur = v;
        n = pow3(depth);
        for (int l = 0; l < depth; l++) begin
            logic [8:0] nxt;
            nxt = '0;
            for (int i = 0; i < 3; i++) begin
                if (3 * i + 2 < n) nxt[i] = maj3(cur[3*i], cur[3*i+1], cur[3*i+2]);
            end
            cur = nxt;
            n = n / 3;
        end
        return cur[0];
    endfunction

endpackage

// File: rtl/rtmr_nand_cell.sv
module rtmr_nand_cell (
    input  logic a,
    input  logic b,
    input  logic flip,
    output logic y
);
    assign y = ~(a & b) ^ flip;
endmodule

// File: rtl/rtmr_maj_cell.sv
module rtmr_maj_cell (
    input  logic x0,
    input  logic x1,
    input  logic x2,
    input  logic flip,
    output logic y
);
    assign y = ((x0 & x1) | (x0 & x2) | (x1 & x2)) ^ flip;
endmodule

// File: rtl/rtmr_vote_stage.sv
module rtmr_vote_stage #(
    parameter int W   = 9,
    parameter int LVL = 1
) (
    input  logic [W-1:0] din,
    input  logic [W-1:0] flip,
    output logic [W-1:0] dout
);
    import rtmr_pkg::*;

    localparam int S   = pow3(LVL - 1);
    localparam int BLK = 3 * S;

    for (genvar q = 0; q < W; q++) begin : g_voter
        localparam int OFF = (q / BLK) * BLK;
        localparam int P   = q % S;
        rtmr_maj_cell i_maj (
            .x0  (din[OFF + P]),
            .x1  (din[OFF + S + P]),
            .x2  (din[OFF + 2*S + P]),
            .flip(flip[q]),
            .y   (dout[q])
        );
    end

    always_comb begin
        if (flip == '0 && (din == '0 || din == '1)) begin
            p_uniform_pass_r3: assert (dout == din)
                else $error("clean stage altered a uniform codeword");
        end
        if ($countones(flip) == 1 && (din == '0 || din == '1)) begin
            p_single_flip_r3: assert ($countones(dout ^ din) == 1)
                else $error("one inverted voter did not change exactly one bit");
        end
    end

endmodule

// File: rtl/rtmr_nand_enc.sv
module rtmr_nand_enc #(
    parameter int K  = 2,
    parameter int W  = rtmr_pkg::pow3(K),
    parameter int MW = (K == 0) ? 1 : K * W
) (
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [W-1:0]  nand_flip,
    input  logic [MW-1:0] vote_flip,
    output logic [W-1:0]  res
);
    import rtmr_pkg::*;

    if (K < 0 || K > 2) begin : g_bad_depth
        $error("rtmr_nand_enc: K must be 0, 1 or 2");
    end

    logic [W-1:0] lvl [K+1];

    for (genvar i = 0; i < W; i++) begin : g_nand
        rtmr_nand_cell i_nand (
            .a   (op_a[i]),
            .b   (op_b[i]),
            .flip(nand_flip[i]),
            .y   (lvl[0][i])
        );
    end

    for (genvar l = 1; l <= K; l++) begin : g_stage
        rtmr_vote_stage #(.W(W), .LVL(l)) i_stage (
            .din (lvl[l-1]),
            .flip(vote_flip[(l-1)*W +: W]),
            .dout(lvl[l])
        );
    end

    assign res = lvl[K];

    always_comb begin
        if (nand_flip == '0 && vote_flip == '0 &&
            (op_a == '0 || op_a == '1) && (op_b == '0 || op_b == '1)) begin
            p_clean_code_r4: assert (res == {W{~(op_a[0] & op_b[0])}})
                else $error("clean encoded NAND gave a non-codeword");
        end
        if ($countones({nand_flip, vote_flip}) <= 1 &&
            (op_a == '0 || op_a == '1) && (op_b == '0 || op_b == '1)) begin
            p_single_tolerated_r5: assert (decode9(9'(res), K) == ~(op_a[0] & op_b[0]))
                else $error("single fault changed the decoded result");
        end
    end

endmodule

// File: tb/test_rtmr_nand_enc.sv
module test_rtmr_nand_enc;

    localparam int  LVL      = 2;
    localparam int  W        = 9;
    localparam int  MW       = 18;
    localparam int  GS       = 3;
    localparam int  NSITE    = W + MW;
    localparam time CLK_HALF = 5ns;
    localparam int  LIMIT    = 20000;

    // {a value, b value, expected result value}
    localparam logic [2:0] VEC [4] = '{3'b001, 3'b011, 3'b101, 3'b110};

    logic clk = 1'b0;
    always #CLK_HALF clk = ~clk;

    logic [W-1:0]  op_a, op_b, nand_flip, res;
    logic [MW-1:0] vote_flip;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    rtmr_nand_enc #(.K(LVL)) i_rtmr_nand_enc (
        .op_a(op_a), .op_b(op_b), .nand_flip(nand_flip),
        .vote_flip(vote_flip), .res(res)
    );

    function automatic logic mj(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (x & z);
    endfunction

    function automatic logic dec(input logic [W-1:0] v);
        return mj(mj(v[0], v[1], v[2]), mj(v[3], v[4], v[5]), mj(v[6], v[7], v[8]));
    endfunction

    function automatic int grp(input int s);
        if (s < W) return s / GS;
        return ((s - W) % W) / GS;
    endfunction

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [NSITE-1:0] f);
        @(posedge clk);
        op_a      = a;
        op_b      = b;
        nand_flip = f[W-1:0];
        vote_flip = f[NSITE-1:W];
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual %0d expected <= %0d cycles", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        op_a = '0; op_b = '0; nand_flip = '0; vote_flip = '0;
        @(negedge clk);
        chk("R4 initial", res, '1);

        // R1 R4: table walk, fault-free uniform operands
        for (int v = 0; v < 4; v++) begin
            drive({W{VEC[v][2]}}, {W{VEC[v][1]}}, '0);
            chk("R1 R4 table", res, {W{VEC[v][0]}});
        end

        // R2: a single NAND flip with a=0 is masked; bit-exact per R6
        drive('0, '1, NSITE'(1));
        chk("R2 R6 nand0 masked", res, '1);

        // R3 R6: single final-stage voter flip inverts exactly that bit
        for (int q = 0; q < W; q++) begin
            logic [NSITE-1:0] f;
            f = '0;
            f[W + W + q] = 1'b1;
            drive('1, '1, f);
            chk("R3 R6 final voter", res, W'(1) << q);
        end

        // R5 R6: every single fault, every operand pair
        for (int v = 0; v < 4; v++) begin
            for (int s = 0; s < NSITE; s++) begin
                logic [NSITE-1:0] f;
                logic [W-1:0] e;
                f = '0;
                f[s] = 1'b1;
                drive({W{VEC[v][2]}}, {W{VEC[v][1]}}, f);
                chk("R5 decode", {W{dec(res)}}, {W{VEC[v][0]}});
                e = {W{VEC[v][0]}};
                if (s >= 2 * W) e[s - 2*W] = ~e[s - 2*W];
                chk("R6 exact", res, e);
            end
        end

        // R7: fault pairs in different top-level groups
        for (int v = 0; v < 4; v++) begin
            for (int s = 0; s < NSITE; s++) begin
                for (int t = s + 1; t < NSITE; t++) begin
                    if (grp(s) != grp(t)) begin
                        logic [NSITE-1:0] f;
                        f = '0;
                        f[s] = 1'b1;
                        f[t] = 1'b1;
                        drive({W{VEC[v][2]}}, {W{VEC[v][1]}}, f);
                        chk("R7 pair", {W{dec(res)}}, {W{VEC[v][0]}});
                    end
                end
            end
        end

        // R8: two NANDs in each of stage-1 blocks 0 and 1 -> full inversion
        drive('1, '1, NSITE'(9'b000_011_011));
        chk("R8 two blocks lost", res, '1);
        drive('0, '1, NSITE'(9'b000_011_011));
        chk("R8 two blocks lost", res, '0);

        // R9: one top-level group of an operand inverted
        drive(9'b000_000_111, '1, '0);
        chk("R9 group deviation zero", res, '1);
        drive(9'b111_111_000, '1, '0);
        chk("R9 group deviation one", res, '0);
        drive('1, 9'b111_000_111, '0);
        chk("R9 group deviation b", res, '0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule